// File: doc/BRIEF.md
# Three-Residue Forward Converter

This block takes an unsigned binary word of 3n bits and produces its residues for the three pairwise coprime moduli 2^n, 2^n−1 and 2^n+1. It sits at the entry of a residue-arithmetic datapath. Each incoming sample is turned into three short words, and each short word is then processed by its own narrow channel.

The word is cut into three n-bit fields: high (a), middle (b) and low (c), with X = a·2^(2n) + b·2^n + c. No divider is used. The power-of-two residue is the low field itself. The 2^n−1 residue uses the fact that 2^n is congruent to 1 for that modulus, so it is a carry-save sum of the three fields followed by an end-around-carry adder. The 2^n+1 residue uses the fact that 2^n is congruent to −1, so it is low minus middle plus high, followed by a single correction of one modulus, either upward or downward.

A word presented with `in_valid` high appears on the three registered residue outputs one clock later, together with `out_valid`. The field width n is a parameter.

Top module: `rns3_fwd_conv`

## Requirements
- R1: `res_pow` equals bits [N-1:0] of the accepted word, which is X mod 2^N.
- R2: `res_minus` equals (a+b+c) mod (2^N−1), where a = bits [3N-1:2N], b = bits [2N-1:N] and c = bits [N-1:0]. Its value always lies in 0 .. 2^N−2.
- R3: When a+b+c is a nonzero multiple of 2^N−1, which includes the all-ones adder result, `res_minus` is 0 and never the all-ones code.
- R4: `res_plus` (N+1 bits) equals (a−b+c) mod (2^N+1). Its value always lies in 0 .. 2^N.
- R5: When a+c < b, the 2^N+1 channel adds the modulus once. When a+c−b ≥ 2^N+1, it subtracts the modulus once. Both cases yield the in-range residue.
- R6: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. The residue outputs change only after an `in_valid` cycle and otherwise hold their values.
- R7: After reset, `out_valid` is 0 and all residue outputs are 0.
- R8: For N=4, the input 2380 (fields 9, 4, 12) gives `res_pow`=12, `res_minus`=10 and `res_plus`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input word qualifier |
| in_word | input | 3N | Unsigned binary input word |
| out_valid | output | 1 | Residues valid, one cycle after `in_valid` |
| res_minus | output | N | Residue modulo 2^N−1 |
| res_pow | output | N | Residue modulo 2^N |
| res_plus | output | N+1 | Residue modulo 2^N+1 |

## Verification
The bench targets field sums that equal 2^N−1 or twice it. A converter that omits the zero mapping would emit an all-ones code there, and one that drops the end-around carry would lose a unit. It also drives middle fields larger than a+c and high/low pairs that push a−b+c past the modulus. A single-sided correction would then give a negative wrap or an out-of-range value. The worked 2380 value, idle cycles that must leave the outputs unchanged, and random words at both N=4 and N=7 complete the set, the last of these catching width slips in the rotated carry.

// File: rtl/rns3_pkg.sv
package rns3_pkg;
  // number of n-bit fields the input word is cut into
  localparam int FIELDS = 3;
  // extra headroom bits for the signed alternating sum
  localparam int ALT_GUARD = 3;
endpackage

// File: rtl/rns_sum3_mersenne.sv
// (a+b+c) mod (2^N-1): carry-save layer, rotated carry, end-around-carry add.
module rns_sum3_mersenne #(
  parameter int N = 4
) (
  input  logic [N-1:0] fa,
  input  logic [N-1:0] fb,
  input  logic [N-1:0] fc,
  output logic [N-1:0] res
);
  logic [N-1:0] csa_s;
  logic [N-1:0] csa_c;
  logic [N-1:0] c_rot;
  logic [N:0]   t_sum;
  logic [N-1:0] eac;

  always_comb begin
    csa_s = fa ^ fb ^ fc;
    csa_c = (fa & fb) | (fa & fc) | (fb & fc);
    // carry of weight 2^N folds back to weight 1
    c_rot = {csa_c[N-2:0], csa_c[N-1]};
    t_sum = {1'b0, csa_s} + {1'b0, c_rot};
    eac   = t_sum[N-1:0] + {{(N-1){1'b0}}, t_sum[N]};
    // all-ones is the second code for zero
    res   = (&eac) ? '0 : eac;
  end
endmodule

// File: rtl/rns_alt3_fermat.sv
// (a-b+c) mod (2^N+1) with a two-sided single correction.
module rns_alt3_fermat #(
  parameter int N = 4
) (
  input  logic [N-1:0] fa,
  input  logic [N-1:0] fb,
  input  logic [N-1:0] fc,
  output logic [N:0]   res
);
  localparam int SW = N + rns3_pkg::ALT_GUARD;
  localparam logic [SW-1:0] MODV = (SW'(1) << N) + SW'(1);

  logic [SW-1:0] ea, eb, ec;
  logic [SW-1:0] raw;
  logic [SW-1:0] up;
  logic [SW-1:0] down;
  logic [SW-1:0] pick;

  always_comb begin
    ea   = {{rns3_pkg::ALT_GUARD{1'b0}}, fa};
    eb   = {{rns3_pkg::ALT_GUARD{1'b0}}, fb};
    ec   = {{rns3_pkg::ALT_GUARD{1'b0}}, fc};
    raw  = ea + ec + (~eb) + SW'(1);
    up   = raw + MODV;
    down = raw - MODV;
    if (raw[SW-1])        pick = up;
    else if (!down[SW-1]) pick = down;
    else                  pick = raw;
    res  = pick[N:0];
  end
endmodule

// File: rtl/rns_out_stage.sv
// Output register bank with explicit load enable.
module rns_out_stage #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [N-1:0] d_minus,
  input  logic [N-1:0] d_pow,
  input  logic [N:0]   d_plus,
  output logic         q_valid,
  output logic [N-1:0] q_minus,
  output logic [N-1:0] q_pow,
  output logic [N:0]   q_plus
);
  logic         valid_nx;
  logic [N-1:0] minus_nx, pow_nx;
  logic [N:0]   plus_nx;

  always_comb begin
    valid_nx = load;
    minus_nx = load ? d_minus : q_minus;
    pow_nx   = load ? d_pow   : q_pow;
    plus_nx  = load ? d_plus  : q_plus;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_minus <= '0;
      q_pow   <= '0;
      q_plus  <= '0;
    end else begin
      q_valid <= valid_nx;
      q_minus <= minus_nx;
      q_pow   <= pow_nx;
      q_plus  <= plus_nx;
    end
  end
endmodule

// File: rtl/rns3_fwd_conv.sv
module rns3_fwd_conv #(
  parameter int N = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic [rns3_pkg::FIELDS*N-1:0] in_word,
  output logic                        out_valid,
  output logic [N-1:0]                res_minus,
  output logic [N-1:0]                res_pow,
  output logic [N:0]                  res_plus
);
  localparam int W = rns3_pkg::FIELDS * N;

  logic rst_meta, rst_core_n;
  logic [N-1:0] f_hi, f_mid, f_lo;
  logic [N-1:0] r_minus;
  logic [N:0]   r_plus;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_core_n <= rst_meta;
    end
  end

  always_comb begin
    f_hi  = in_word[W-1:2*N];
    f_mid = in_word[2*N-1:N];
    f_lo  = in_word[N-1:0];
  end

  rns_sum3_mersenne #(.N(N)) u_minus (
    .fa(f_hi), .fb(f_mid), .fc(f_lo), .res(r_minus)
  );

  rns_alt3_fermat #(.N(N)) u_plus (
    .fa(f_hi), .fb(f_mid), .fc(f_lo), .res(r_plus)
  );

  rns_out_stage #(.N(N)) u_out (
    .clk(clk), .rst_n(rst_core_n), .load(in_valid),
    .d_minus(r_minus), .d_pow(f_lo), .d_plus(r_plus),
    .q_valid(out_valid), .q_minus(res_minus), .q_pow(res_pow), .q_plus(res_plus)
  );
endmodule

// File: rtl/rns3_fwd_conv_chk.sv
module rns3_fwd_conv_chk #(
  parameter int N = 4
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          in_valid,
  input logic [rns3_pkg::FIELDS*N-1:0] in_word,
  input logic                          out_valid,
  input logic [N-1:0]                  res_minus,
  input logic [N-1:0]                  res_pow,
  input logic [N:0]                    res_plus
);
  int ia, ib, ic, m_minus, m_plus, alt;
  logic [N-1:0] exp_minus;
  logic [N:0]   exp_plus;

  always_comb begin
    ia = int'(in_word[3*N-1:2*N]);
    ib = int'(in_word[2*N-1:N]);
    ic = int'(in_word[N-1:0]);
    m_minus = (1 << N) - 1;
    m_plus  = (1 << N) + 1;
    exp_minus = N'((ia + ib + ic) % m_minus);
    alt = (ia - ib + ic) % m_plus;
    if (alt < 0) alt = alt + m_plus;
    exp_plus = (N+1)'(alt);
  end

  assert_valid_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(res_minus) && $stable(res_pow) && $stable(res_plus)));
  assert_pow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (res_pow == $past(in_word[N-1:0])));
  assert_minus_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (res_minus == $past(exp_minus)));
  assert_no_allones_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(&res_minus));
  assert_plus_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (res_plus == $past(exp_plus)));
  assert_plus_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    int'(res_plus) <= (1 << N));
endmodule

bind rns3_fwd_conv rns3_fwd_conv_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_core_n), .in_valid(in_valid), .in_word(in_word),
  .out_valid(out_valid), .res_minus(res_minus), .res_pow(res_pow), .res_plus(res_plus)
);

// File: tb/sim_rns3_fwd_conv.sv
`timescale 1ns/1ps
module sim_rns3_fwd_conv;
  logic clk = 1'b0;
  logic rst_n;
  always #5 clk = ~clk;

  logic        v4, v7;
  logic [11:0] w4;
  logic [20:0] w7;
  logic        ov4, ov7;
  logic [3:0]  m4, p4;
  logic [4:0]  q4;
  logic [6:0]  m7, p7;
  logic [7:0]  q7;

  int errors = 0;
  int checks = 0;

  rns3_fwd_conv #(.N(4)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(v4), .in_word(w4),
    .out_valid(ov4), .res_minus(m4), .res_pow(p4), .res_plus(q4));
  rns3_fwd_conv #(.N(7)) u1 (
    .clk(clk), .rst_n(rst_n), .in_valid(v7), .in_word(w7),
    .out_valid(ov7), .res_minus(m7), .res_pow(p7), .res_plus(q7));

  function automatic int fld(int n, longint x, int k);
    return int'((x >> (k * n)) & ((64'd1 << n) - 1));
  endfunction
  function automatic int e_pow(int n, longint x);
    return fld(n, x, 0);
  endfunction
  function automatic int e_minus(int n, longint x);
    return (fld(n, x, 2) + fld(n, x, 1) + fld(n, x, 0)) % ((1 << n) - 1);
  endfunction
  function automatic int e_plus(int n, longint x);
    int v;
    v = (fld(n, x, 2) - fld(n, x, 1) + fld(n, x, 0)) % ((1 << n) + 1);
    if (v < 0) v = v + (1 << n) + 1;
    return v;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive one word into each instance, check one cycle later (R1 R2 R4 R6)
  task automatic apply(logic [11:0] x4, logic [20:0] x7, string tag);
    @(negedge clk);
    v4 = 1'b1; w4 = x4; v7 = 1'b1; w7 = x7;
    @(negedge clk);
    v4 = 1'b0; v7 = 1'b0;
    chk({tag, " R6 valid n4"}, int'(ov4), 1);
    chk({tag, " R6 valid n7"}, int'(ov7), 1);
    chk({tag, " R1 n4"}, int'(p4), e_pow(4, longint'(x4)));
    chk({tag, " R1 n7"}, int'(p7), e_pow(7, longint'(x7)));
    chk({tag, " R2 n4"}, int'(m4), e_minus(4, longint'(x4)));
    chk({tag, " R2 n7"}, int'(m7), e_minus(7, longint'(x7)));
    chk({tag, " R4 n4"}, int'(q4), e_plus(4, longint'(x4)));
    chk({tag, " R4 n7"}, int'(q7), e_plus(7, longint'(x7)));
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [3:0] pm4, pp4;
    logic [4:0] pq4;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; v4 = 1'b0; v7 = 1'b0; w4 = '0; w7 = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R7 reset state
    chk("R7 valid n4", int'(ov4), 0);
    chk("R7 valid n7", int'(ov7), 0);
    chk("R7 residues n4", int'(m4) + int'(p4) + int'(q4), 0);
    chk("R7 residues n7", int'(m7) + int'(p7) + int'(q7), 0);

    // R8 worked value 2380 = fields 9,4,12
    apply(12'd2380, 21'd0, "R8");
    chk("R8 pow", int'(p4), 12);
    chk("R8 minus", int'(m4), 10);
    chk("R8 plus", int'(q4), 0);

    // R3 sums equal to one or more multiples of 2^n-1
    apply({4'd15, 4'd0, 4'd0}, {7'd127, 7'd0, 7'd0}, "R3a");
    chk("R3 single n4", int'(m4), 0);
    chk("R3 single n7", int'(m7), 0);
    apply({4'd15, 4'd15, 4'd15}, {7'd100, 7'd27, 7'd0}, "R3b");
    chk("R3 triple n4", int'(m4), 0);
    chk("R3 split n7", int'(m7), 0);
    apply({4'd7, 4'd8, 4'd15}, {7'd127, 7'd127, 7'd0}, "R3c");
    chk("R3 double n4", int'(m4), 0);
    chk("R3 double n7", int'(m7), 0);

    // R5 negative and over-modulus alternating sums
    apply({4'd0, 4'd15, 4'd0}, {7'd0, 7'd127, 7'd1}, "R5neg");
    chk("R5 neg n4", int'(q4), 2);
    chk("R5 neg n7", int'(q7), 3);
    apply({4'd15, 4'd0, 4'd15}, {7'd127, 7'd0, 7'd127}, "R5over");
    chk("R5 over n4", int'(q4), 13);
    chk("R5 over n7", int'(q7), 125);
    apply({4'd9, 4'd1, 4'd8}, {7'd64, 7'd0, 7'd64}, "R5edge");
    chk("R5 eq mod n4", int'(q4), 16);
    chk("R5 top n7", int'(q7), 128);

    // R6 idle cycles: outputs hold while input word changes
    pm4 = m4; pp4 = p4; pq4 = q4;
    w4 = 12'hA5C; w7 = 21'h1ABCDE;
    @(negedge clk);
    chk("R6 idle valid", int'(ov4), 0);
    chk("R6 hold minus", int'(m4), int'(pm4));
    chk("R6 hold pow", int'(p4), int'(pp4));
    chk("R6 hold plus", int'(q4), int'(pq4));

    // random words, mixed with occasional idle gaps
    for (int i = 0; i < 300; i++) begin
      apply(12'($urandom), 21'($urandom), "rand");
      if (($urandom % 4) == 0) @(negedge clk);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule